// File: doc/BRIEF.md
# Scan-Testable Up/Down Loadable Counter

This block is a parameterised binary counter with synchronous reset, count enable, parallel load and a direction input. A terminal-count flag goes high when the next step in the current direction would wrap. The counter is meant for control paths that also have to be observable and controllable during manufacturing test.

A test-mode input turns the count register into a serial shift register. The propagation chain that normally carries the increment or decrement ripple is reused to pass each bit to its upper neighbour. The lowest bit takes a serial data input, and the top bit drives a serial data output. During shifting the parallel count output stays live, so logic fed by the counter can take scanned-in stimulus directly.

Top module: `scan_updown_counter`

## Requirements
- R1: With `rst` high at a rising clock edge, the count becomes zero whatever the mode and the other inputs.
- R2: In normal mode (`test_i`=0), with `load_i`=0, `en_i`=1 and `dir_i`=0, the count increases by one per clock, modulo 2^W.
- R3: In normal mode, with `load_i`=0, `en_i`=1 and `dir_i`=1, the count decreases by one per clock, modulo 2^W.
- R4: In normal mode with `load_i`=1, the count takes `ext_i` on the next clock, whatever `en_i` and `dir_i` are.
- R5: In normal mode with `load_i`=0 and `en_i`=0, the count holds its value.
- R6: In normal mode, `tc_o` is high exactly when `dir_i`=0 and the count is all ones, or when `dir_i`=1 and the count is zero. This holds whatever `en_i` is.
- R7: In test mode with `en_i`=1, each clock moves count bit i to bit i+1 and puts `sdi_i` into bit 0. `sdo_o` always equals the top count bit.
- R8: In test mode, `load_i` and `dir_i` have no effect on the count.
- R9: In test mode with `en_i`=0, the count holds its value.
- R10: In test mode, `tc_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Enables counting (normal mode) or shifting (test mode) |
| load_i | input | 1 | Parallel load request, normal mode only |
| dir_i | input | 1 | Direction: 0 counts up, 1 counts down |
| ext_i | input | W | Parallel load data |
| test_i | input | 1 | Test-mode select: 1 makes the register a shift chain |
| sdi_i | input | 1 | Serial data into bit 0 in test mode |
| count_o | output | W | Registered count value, live in both modes |
| sdo_o | output | 1 | Serial data out, the top count bit |
| tc_o | output | 1 | Terminal count flag |

## Verification
The bench builds the counter with W=4, so every one of the 16 states can be loaded and stepped up and down. It also checks the terminal-count flag in each direction, with enable both high and low. Four bits is short enough to scan a complete pattern in and shift it back out through the serial output. The wrap from 15 to 0 and from 0 to 15 falls inside the sweep. Priority is tested by scanning with load asserted and conflicting load data present.

// File: rtl/scan_cnt_pkg.sv
package scan_cnt_pkg;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_COUNT = 2'd2,
    OP_SHIFT = 2'd3
  } cnt_op_e;

  // Test mode wins over load; enable gates both counting and shifting.
  function automatic cnt_op_e pick_op(input logic test, input logic load,
                                      input logic en);
    if (test)      return en ? OP_SHIFT : OP_HOLD;
    else if (load) return OP_LOAD;
    else if (en)   return OP_COUNT;
    else           return OP_HOLD;
  endfunction

endpackage

// File: rtl/scan_cnt_stage.sv
// One bit of the shared propagation chain.
// Normal mode: the carry passes when this bit equals the "ripple" value for
// the direction (1 for up, 0 for down); the bit toggles when the carry arrives.
// Test mode: the carry into the stage is the lower neighbour's bit, and the
// stage forwards its own bit upward.
module scan_cnt_stage (
  input  logic q_bit,
  input  logic dir,
  input  logic test,
  input  logic c_in,
  output logic c_out,
  output logic nxt
);
  logic pass;

  always_comb begin
    pass = q_bit ^ dir;
    if (test) begin
      c_out = q_bit;
      nxt   = c_in;
    end else begin
      c_out = c_in & pass;
      nxt   = q_bit ^ c_in;
    end
  end
endmodule

// File: rtl/scan_cnt_chain.sv
module scan_cnt_chain #(
  parameter int W = 8
) (
  input  logic [W-1:0] q,
  input  logic         dir,
  input  logic         test,
  input  logic         sdi,
  output logic [W-1:0] nxt,
  output logic         carry_top
);
  logic [W:0] c;

  // Seed: constant 1 while counting, serial input while scanning.
  assign c[0] = test ? sdi : 1'b1;

  for (genvar i = 0; i < W; i++) begin : g_stage
    scan_cnt_stage u_stage (
      .q_bit (q[i]),
      .dir   (dir),
      .test  (test),
      .c_in  (c[i]),
      .c_out (c[i+1]),
      .nxt   (nxt[i])
    );
  end

  assign carry_top = c[W];
endmodule

// File: rtl/scan_cnt_reg.sv
module scan_cnt_reg
  import scan_cnt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         load,
  input  logic         test,
  input  logic         sdi,
  input  logic [W-1:0] ext,
  input  logic [W-1:0] chain_nxt,
  output logic [W-1:0] q
);
  cnt_op_e op;

  always_comb op = pick_op(test, load, en);

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else begin
      unique case (op)
        OP_LOAD:  q <= ext;
        OP_COUNT,
        OP_SHIFT: q <= chain_nxt;
        default:  q <= q;
      endcase
    end
  end

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (q == '0));

  assert_load_takes_ext_R4: assert property (@(posedge clk) disable iff (rst)
    (!test && load) |=> (q == $past(ext)));

  assert_hold_idle_R5: assert property (@(posedge clk) disable iff (rst)
    (!test && !load && !en) |=> $stable(q));

  assert_shift_step_R7: assert property (@(posedge clk) disable iff (rst)
    (test && en) |=> (q == {$past(q[W-2:0]), $past(sdi)}));

  assert_test_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (test && !en) |=> $stable(q));
endmodule

// File: rtl/scan_updown_counter.sv
module scan_updown_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_i,
  input  logic         load_i,
  input  logic         dir_i,
  input  logic [W-1:0] ext_i,
  input  logic         test_i,
  input  logic         sdi_i,
  output logic [W-1:0] count_o,
  output logic         sdo_o,
  output logic         tc_o
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  logic [W-1:0] q;
  logic [W-1:0] chain_nxt;
  logic         carry_top;

  scan_cnt_chain #(.W(W)) u_chain (
    .q         (q),
    .dir       (dir_i),
    .test      (test_i),
    .sdi       (sdi_i),
    .nxt       (chain_nxt),
    .carry_top (carry_top)
  );

  scan_cnt_reg #(.W(W)) u_reg (
    .clk       (clk),
    .rst       (rst),
    .en        (en_i),
    .load      (load_i),
    .test      (test_i),
    .sdi       (sdi_i),
    .ext       (ext_i),
    .chain_nxt (chain_nxt),
    .q         (q)
  );

  assign count_o = q;
  assign sdo_o   = q[W-1];
  assign tc_o    = !test_i && carry_top;

  assert_count_up_R2: assert property (@(posedge clk) disable iff (rst)
    (!test_i && !load_i && en_i && !dir_i) |=> (count_o == $past(count_o) + 1'b1));

  assert_count_down_R3: assert property (@(posedge clk) disable iff (rst)
    (!test_i && !load_i && en_i && dir_i) |=> (count_o == $past(count_o) - 1'b1));

  assert_tc_matches_R6: assert property (@(posedge clk) disable iff (rst)
    !test_i |-> (tc_o == (dir_i ? (count_o == '0) : (count_o == ALL_ONES))));

  assert_tc_low_test_R10: assert property (@(posedge clk) disable iff (rst)
    test_i |-> !tc_o);
endmodule

// File: tb/scan_updown_counter_test.sv
`timescale 1ns/1ps
module scan_updown_counter_test;
  localparam int W = 4;
  localparam int M = 1 << W;

  logic clk = 0;
  logic rst = 1;
  logic en_i = 0, load_i = 0, dir_i = 0, test_i = 0, sdi_i = 0;
  logic [W-1:0] ext_i = '0;
  logic [W-1:0] count_o;
  logic sdo_o, tc_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  scan_updown_counter #(.W(W)) uut (
    .clk(clk), .rst(rst), .en_i(en_i), .load_i(load_i), .dir_i(dir_i),
    .ext_i(ext_i), .test_i(test_i), .sdi_i(sdi_i),
    .count_o(count_o), .sdo_o(sdo_o), .tc_o(tc_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive at negedge, let one posedge happen, return at the next negedge.
  task automatic step(input logic t, input logic ld, input logic e,
                      input logic d, input logic s, input int x);
    test_i = t; load_i = ld; en_i = e; dir_i = d; sdi_i = s;
    ext_i = W'(x);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic put(input int v);
    step(0, 1, 0, 0, 0, v);
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    chk("R1 reset value", count_o, 0);
    rst = 0;

    // R4: every value loads, with enable and direction varied
    for (int v = 0; v < M; v++) begin
      step(0, 1, v[0], v[1], 0, v);
      chk("R4 load", count_o, v);
    end

    // R2 / R3 / R6: one step from every value in both directions
    for (int v = 0; v < M; v++) begin
      for (int d = 0; d < 2; d++) begin
        put(v);
        dir_i = d[0]; en_i = 0;
        #1;
        chk("R6 tc en=0", tc_o, (d == 0) ? (v == M-1) : (v == 0));
        en_i = 1;
        #1;
        chk("R6 tc en=1", tc_o, (d == 0) ? (v == M-1) : (v == 0));
        step(0, 0, 1, d[0], 0, 0);
        if (d == 0) chk("R2 up", count_o, (v + 1) % M);
        else        chk("R3 down", count_o, (v + M - 1) % M);
      end
    end

    // R2 long run with wrap
    put(M - 3);
    for (int k = 0; k < 5; k++) step(0, 0, 1, 0, 0, 0);
    chk("R2 wrap up", count_o, (M - 3 + 5) % M);
    // R3 long run with wrap
    put(2);
    for (int k = 0; k < 5; k++) step(0, 0, 1, 1, 0, 0);
    chk("R3 wrap down", count_o, (2 - 5 + M) % M);

    // R5: hold with enable low
    put(9);
    for (int k = 0; k < 3; k++) step(0, 0, 0, k[0], 0, 0);
    chk("R5 hold", count_o, 9);

    // R7 / R8 / R10: scan in 4'b1011 msb first with load and dir fighting
    put(0);
    begin
      int pat = 4'b1011;
      int exp = 0;
      for (int k = W - 1; k >= 0; k--) begin
        step(1, 1, 1, k[0], pat[k], 4'b0110);
        exp = ((exp << 1) | ((pat >> k) & 1)) % M;
        chk("R7 shift in", count_o, exp);
        chk("R8 load ignored", count_o, exp);
        chk("R7 sdo top bit", sdo_o, (exp >> (W - 1)) & 1);
        chk("R10 tc low", tc_o, 0);
      end
      // R9: test mode, enable low holds
      step(1, 1, 0, 1, 1, 0);
      chk("R9 test hold", count_o, pat);
      // R7: shift the pattern back out, zeros in
      for (int k = W - 1; k >= 0; k--) begin
        chk("R7 sdo out", sdo_o, (pat >> k) & 1);
        step(1, 0, 1, 0, 0, 0);
      end
      chk("R7 flushed", count_o, 0);
    end

    // R10: tc low in test mode at terminal values
    put(M - 1);
    test_i = 1; dir_i = 0; en_i = 0;
    #1;
    chk("R10 tc low at ones", tc_o, 0);
    test_i = 0;
    #1;
    chk("R6 tc back at ones", tc_o, 1);

    // R1: reset overrides test-mode shifting
    put(7);
    rst = 1;
    step(1, 0, 1, 0, 1, 0);
    chk("R1 reset in test", count_o, 0);
    rst = 0;

    done = 1;
    finish_up();
  end
endmodule